// File: doc/BRIEF.md
# Paged Indirect Operand Address Resolver

This block works out the effective word address of a memory-reference instruction on a 16-bit, word-addressed machine with a 32K-word space. A direct reference can reach only two places: the 1024-word page that holds the instruction, or page zero. The block forms that address by joining a page number to a 10-bit in-page offset. It does not add anything to the program counter.

When the instruction asks for indirection, the block reads the addressed word through a single-port synchronous memory. If that word has its top bit set, its low 15 bits point to the next word to read. The walk continues until a word with a clear top bit appears, and that word's low 15 bits become the result. A depth limit ends a pointer cycle with an error flag. The block reports how many reads it made. A separate combinational path splits a 16-bit byte address into a word address and a byte lane.

Top module: `ea_resolver`

## Requirements
- R1: The instruction word carries the indirect flag in bit 15, the page select in bit 10 and the in-page offset in bits 9:0. With page select 0, the direct address is the offset itself, which lies in page zero.
- R2: With page select 1, the direct address is PC bits 14:10 joined above the offset. No PC-relative sum is formed.
- R3: Instruction bits 14:11 have no effect on the result.
- R4: For a start without indirection, `done` pulses in the cycle after the start edge, with `eff_addr` equal to the direct address, `depth` 0, `err` 0, and no memory read.
- R5: With indirection, the block reads the direct address first. While the word read has bit 15 set, its bits 14:0 name the next read. The first word with bit 15 clear gives `eff_addr` from its bits 14:0, and `depth` equals the number of reads made.
- R6: Each level issues exactly one `mem_rd_en` cycle, and data returns one cycle after the read. A result after N reads is signalled 2N+1 cycles after start is presented: the block takes two cycles per level.
- R7: If MAX_DEPTH reads all return bit 15 set, resolution ends with `err` 1, `depth` = MAX_DEPTH and `eff_addr` 0.
- R8: While `busy` is high, `start` is ignored. The result in progress is unchanged, and no extra `done` follows it.
- R9: Byte address B maps to word address B>>1 and lane B[0]. Lane 0 is the upper byte of the word and lane 1 the lower.
- R10: After reset, `done`, `busy`, `err` and `mem_rd_en` are 0.
- R11: `done` is high for exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin resolving `instr` (accepted only when idle) |
| instr | input | 16 | Memory-reference instruction word |
| pc | input | 15 | Word address of the instruction |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 15 | Memory read word address |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | Result valid pulse |
| eff_addr | output | 15 | Resolved effective word address |
| depth | output | DEPTH_W | Number of pointer reads made |
| err | output | 1 | Depth limit reached |
| byte_addr | input | 16 | Byte address to convert |
| byte_word | output | 15 | Word holding that byte |
| byte_lane | output | 1 | 0 = upper byte, 1 = lower byte |

## Verification
The hardest state to reach is a run that hits the depth limit. A chain must keep returning words with the top bit set for MAX_DEPTH reads, and no ordinary data produces that. The bench memory holds a word that points to its own address, which forms a one-word cycle and drives the walker straight to the limit. Multi-level chains that cross page boundaries, and a start pulsed in the middle of a walk, are also built from this small set of memory entries.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 15;
    localparam int OFS_W    = 10;
    localparam int PAGE_W   = ADDR_W - OFS_W;
    localparam int LINK_BIT = WORD_W - 1;
    localparam int PSEL_BIT = OFS_W;

    typedef enum logic [1:0] {
        WALK_IDLE,
        WALK_READ,
        WALK_WAIT
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] word;
        logic              lane;
    } byte_ref_t;

    function automatic logic is_link(input logic [WORD_W-1:0] w);
        return w[LINK_BIT];
    endfunction

    function automatic logic [ADDR_W-1:0] link_target(input logic [WORD_W-1:0] w);
        return w[ADDR_W-1:0];
    endfunction

    function automatic byte_ref_t split_byte(input logic [WORD_W-1:0] b);
        byte_ref_t r;
        r.word = b[WORD_W-1:1];
        r.lane = b[0];
        return r;
    endfunction

endpackage

// File: rtl/ea_direct_form.sv
module ea_direct_form
    import ea_pkg::*;
(
    input  logic              page_sel,
    input  logic [OFS_W-1:0]  offset,
    input  logic [PAGE_W-1:0] cur_page,
    output logic [ADDR_W-1:0] dir_addr
);
    logic [PAGE_W-1:0] page_num;

    always_comb begin
        page_num = page_sel ? cur_page : '0;
        dir_addr = {page_num, offset};
    end

endmodule

// File: rtl/ea_byte_map.sv
module ea_byte_map
    import ea_pkg::*;
(
    input  logic [WORD_W-1:0] byte_addr,
    output logic [ADDR_W-1:0] byte_word,
    output logic              byte_lane
);
    byte_ref_t ref_w;

    always_comb begin
        ref_w     = split_byte(byte_addr);
        byte_word = ref_w.word;
        byte_lane = ref_w.lane;
    end

endmodule

// File: rtl/ea_chain_walk.sv
module ea_chain_walk
    import ea_pkg::*;
#(
    parameter int MAX_DEPTH = 64,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               indirect,
    input  logic [ADDR_W-1:0]  dir_addr,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [WORD_W-1:0]  mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [ADDR_W-1:0]  eff_addr,
    output logic [DEPTH_W-1:0] depth,
    output logic               err
);
    localparam logic [DEPTH_W-1:0] LIMIT = DEPTH_W'(MAX_DEPTH);

    walk_state_e        state_q;
    logic [ADDR_W-1:0]  ptr_q;
    logic [DEPTH_W-1:0] lvl_q;
    logic [DEPTH_W-1:0] lvl_nx;

    assign lvl_nx    = lvl_q + DEPTH_W'(1);
    assign busy      = (state_q != WALK_IDLE);
    assign mem_rd_en = (state_q == WALK_READ);
    assign mem_addr  = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= WALK_IDLE;
            ptr_q    <= '0;
            lvl_q    <= '0;
            done     <= 1'b0;
            eff_addr <= '0;
            depth    <= '0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                WALK_IDLE: begin
                    if (start) begin
                        if (indirect) begin
                            state_q <= WALK_READ;
                            ptr_q   <= dir_addr;
                            lvl_q   <= '0;
                        end else begin
                            done     <= 1'b1;
                            eff_addr <= dir_addr;
                            depth    <= '0;
                            err      <= 1'b0;
                        end
                    end
                end
                WALK_READ: begin
                    state_q <= WALK_WAIT;
                end
                WALK_WAIT: begin
                    if (!is_link(mem_rdata)) begin
                        state_q  <= WALK_IDLE;
                        done     <= 1'b1;
                        eff_addr <= link_target(mem_rdata);
                        depth    <= lvl_nx;
                        err      <= 1'b0;
                    end else if (lvl_nx == LIMIT) begin
                        state_q  <= WALK_IDLE;
                        done     <= 1'b1;
                        eff_addr <= '0;
                        depth    <= LIMIT;
                        err      <= 1'b1;
                    end else begin
                        state_q <= WALK_READ;
                        ptr_q   <= link_target(mem_rdata);
                        lvl_q   <= lvl_nx;
                    end
                end
                default: state_q <= WALK_IDLE;
            endcase
        end
    end

    AST_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |-> busy) else $error("read outside a walk"); // R6

    AST_SINGLE_READ_SLOT: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> !mem_rd_en) else $error("back-to-back reads"); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R11

    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (depth <= LIMIT)) else $error("depth above limit"); // R7

    AST_ERR_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (depth == LIMIT && eff_addr == '0)) else $error("bad error result"); // R7

    AST_TERMINAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done && !err && depth != '0) |-> !$past(mem_rdata[LINK_BIT])) else $error("ended on a link word"); // R5

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy) else $error("done while walking"); // R8

endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
    import ea_pkg::*;
#(
    parameter int MAX_DEPTH = 64,
    localparam int DEPTH_W  = $clog2(MAX_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [15:0]        instr,
    input  logic [14:0]        pc,
    output logic               mem_rd_en,
    output logic [14:0]        mem_addr,
    input  logic [15:0]        mem_rdata,
    output logic               busy,
    output logic               done,
    output logic [14:0]        eff_addr,
    output logic [DEPTH_W-1:0] depth,
    output logic               err,
    input  logic [15:0]        byte_addr,
    output logic [14:0]        byte_word,
    output logic               byte_lane
);
    logic [ADDR_W-1:0] dir_addr;
    logic              unused_spare_bits;

    assign unused_spare_bits = ^{instr[LINK_BIT-1:PSEL_BIT+1], pc[OFS_W-1:0]};

    ea_direct_form u_direct (
        .page_sel (instr[PSEL_BIT]),
        .offset   (instr[OFS_W-1:0]),
        .cur_page (pc[ADDR_W-1:OFS_W]),
        .dir_addr (dir_addr)
    );

    ea_chain_walk #(.MAX_DEPTH(MAX_DEPTH)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .indirect  (instr[LINK_BIT]),
        .dir_addr  (dir_addr),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .eff_addr  (eff_addr),
        .depth     (depth),
        .err       (err)
    );

    ea_byte_map u_bytes (
        .byte_addr (byte_addr),
        .byte_word (byte_word),
        .byte_lane (byte_lane)
    );

endmodule

// File: tb/ea_resolver_tb_top.sv
module ea_resolver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [14:0] pc = '0;
    logic        mem_rd_en;
    logic [14:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic        busy, done, err;
    logic [14:0] eff_addr;
    logic [6:0]  depth;
    logic [15:0] byte_addr = '0;
    logic [14:0] byte_word;
    logic        byte_lane;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_resolver dut_i (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc(pc),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .eff_addr(eff_addr), .depth(depth), .err(err),
        .byte_addr(byte_addr), .byte_word(byte_word), .byte_lane(byte_lane)
    );

    function automatic logic [15:0] mem_word(input logic [14:0] a);
        case (a)
            15'h0010: return 16'h0123;
            15'h0020: return 16'h8030;
            15'h0030: return 16'h8C40;
            15'h0C40: return 16'h1555;
            15'h1405: return 16'h8010;
            15'h0050: return 16'h8050;
            15'h7FFF: return 16'h0001;
            default:  return 16'h0ABC;
        endcase
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

    // {instr, pc, expected eff_addr, expected depth, expected err}
    localparam logic [53:0] VEC [NVEC] = '{
        {16'h0010, 15'h1234, 15'h0010, 7'd0,  1'b0},  // R1 page zero
        {16'h0405, 15'h1523, 15'h1405, 7'd0,  1'b0},  // R2 current page
        {16'h7805, 15'h1523, 15'h0005, 7'd0,  1'b0},  // R3 spare bits set
        {16'h03FF, 15'h7FFF, 15'h03FF, 7'd0,  1'b0},  // R1 top offset
        {16'h07FF, 15'h7C01, 15'h7FFF, 7'd0,  1'b0},  // R2 last page
        {16'h8010, 15'h0000, 15'h0123, 7'd1,  1'b0},  // R5 one level
        {16'h8020, 15'h0000, 15'h1555, 7'd3,  1'b0},  // R5 three levels
        {16'h8405, 15'h1523, 15'h0123, 7'd2,  1'b0},  // R5 from current page
        {16'h87FF, 15'h7C00, 15'h0001, 7'd1,  1'b0},  // R5 top word
        {16'h8060, 15'h2222, 15'h0ABC, 7'd1,  1'b0},  // R5 plain word
        {16'hFC50, 15'h0123, 15'h0000, 7'd64, 1'b1}   // R7 self loop, R3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drives one start and waits for done; returns cycles and reads seen.
    task automatic run(input logic [15:0] ins, input logic [14:0] p,
                       output int cyc, output int reads);
        @(negedge clk);
        instr = ins; pc = p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1; reads = 0;
        while (!done && cyc < 400) begin
            if (mem_rd_en) reads++;
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int cyc, reads;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 done", 32'(done), 0);
        chk("R10 busy", 32'(busy), 0);
        chk("R10 err", 32'(err), 0);
        chk("R10 mem_rd_en", 32'(mem_rd_en), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v_ins; logic [14:0] v_pc, v_eff; logic [6:0] v_dep; logic v_err;
            {v_ins, v_pc, v_eff, v_dep, v_err} = VEC[i];
            run(v_ins, v_pc, cyc, reads);
            chk("R1/R2/R5 eff_addr", 32'(eff_addr), 32'(v_eff));
            chk("R4/R5/R7 depth", 32'(depth), 32'(v_dep));
            chk("R7 err", 32'(err), 32'(v_err));
            chk("R6 latency", 32'(cyc), 32'(2 * v_dep + 1));
            chk("R6 reads", 32'(reads), 32'(v_dep));
            @(negedge clk);
            chk("R11 done low after pulse", 32'(done), 0);
        end

        // R8: a second start during a walk is ignored
        @(negedge clk);
        instr = 16'h8020; pc = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        instr = 16'h0010; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        instr = 16'h0000;
        cyc = 0;
        while (!done && cyc < 50) begin @(negedge clk); cyc++; end
        chk("R8 eff_addr", 32'(eff_addr), 32'h1555);
        chk("R8 depth", 32'(depth), 3);
        repeat (3) begin
            @(negedge clk);
            chk("R8 no extra done", 32'(done), 0);
        end

        // R9 byte lanes
        byte_addr = 16'h0000; #1;
        chk("R9 word 0000", 32'(byte_word), 0);
        chk("R9 lane 0000", 32'(byte_lane), 0);
        byte_addr = 16'h0001; #1;
        chk("R9 word 0001", 32'(byte_word), 0);
        chk("R9 lane 0001", 32'(byte_lane), 1);
        byte_addr = 16'hFFFF; #1;
        chk("R9 word FFFF", 32'(byte_word), 32'h7FFF);
        chk("R9 lane FFFF", 32'(byte_lane), 1);
        byte_addr = 16'hABCD; #1;
        chk("R9 word ABCD", 32'(byte_word), 32'h55E6);
        chk("R9 lane ABCD", 32'(byte_lane), 1);
        byte_addr = 16'h1234; #1;
        chk("R9 lane 1234", 32'(byte_lane), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule